// File: doc/BRIEF.md
# Conditional Branch Resolution Unit

This block settles conditional branches. An instruction word arrives together with its own program counter. If bits 31:26 carry the branch opcode, the unit evaluates a 5-bit condition field against the status flags it holds. It then reports whether the branch is taken, which PC fetch should continue from, and whether the pipeline must be flushed. The target comes from one of two places, chosen by a single mode bit. In register mode it is the full value of a register file entry, read through a combinational read port. In PC-relative mode it is the branch's PC plus one plus a sign-extended 16-bit displacement.

The unit also owns the N, Z, V and C flags. Writeback results offer new flags every cycle, but the flags are latched only for results that qualify. A taken branch blocks new issue for a fixed number of cycles (four by default), which lets the redirected fetch arrive. A branch that is not taken resolves in a single cycle.

Top module: `br_resolve_unit`

## Requirements
- R1: After reset, `busy`, `resolve_valid`, `taken` and `flush` are 0, and `flags` (packed {N,Z,V,C}, N in bit 3) is 0.
- R2: An instruction is accepted only when `issue_valid` is 1, `busy` is 0 and bits 31:26 equal 6'b011010. An accepted branch raises `resolve_valid` for exactly one cycle after the accepting clock edge. Any other word has no effect on the outputs.
- R3: The condition field is bits 20:16, evaluated on the flags latched before the issue edge. The codes are: 0 always, 1 C, 2 C|Z, 3 !C&!Z, 4 !C, 5 Z, 6 !Z, 7 N^V, 8 (N^V)|Z, 9 !(N^V)&!Z, 10 !(N^V), 11 !V, 12 V, 13 !N, 14 N, 15 !N&!Z, 16 N|Z, 17 C|V, 18 !C&!V, 19 Z|V. Codes 20 to 31 are never taken.
- R4: For a branch that is not taken, `new_pc` is the branch PC plus 1, modulo 2^32.
- R5: When bit 25 is 0 (register mode), `rf_idx` carries bits 4:0, and a taken branch sets `new_pc` to `rf_data`. An index above 27 makes the branch not taken.
- R6: When bit 25 is 1, a taken branch sets `new_pc` to the branch PC + 1 + the sign-extended bits 15:0, modulo 2^32.
- R7: `flush` is 1 exactly when a resolved branch is taken.
- R8: After a taken branch, `busy` is 1 for the next TAKEN_CYCLES-1 cycles. No issue is accepted during that time, so the branch occupies TAKEN_CYCLES cycles in total.
- R9: `res_flags` is latched when `res_valid` is 1 and either `res_dst` is 0 to 7 or `res_cmp` is 1. Otherwise the flags hold, and a branch never changes them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_valid | input | 1 | An instruction word is presented |
| instr | input | 32 | Instruction word |
| instr_pc | input | 32 | PC of the presented instruction |
| rf_idx | output | 5 | Register-file read index (bits 4:0) |
| rf_data | input | 32 | Register-file read data for `rf_idx` |
| res_valid | input | 1 | A writeback result is offered |
| res_dst | input | 5 | Destination register of that result |
| res_cmp | input | 1 | Result comes from a compare or bit-test |
| res_flags | input | 4 | Flags of that result, {N,Z,V,C} |
| busy | output | 1 | Issue held off after a taken branch |
| resolve_valid | output | 1 | A branch resolved at the last edge |
| taken | output | 1 | The resolved branch was taken |
| flush | output | 1 | Pipeline flush request |
| new_pc | output | 32 | Next fetch PC after the resolved branch |
| flags | output | 4 | Latched flags {N,Z,V,C} |

## Verification
The bench walks the condition codes over flag patterns chosen to separate each code from its opposite, and it includes an unused code. A wrong mapping would take branches that should fall through. It drives the wrap cases: PC 0xFFFFFFFF going to 0, and the most negative displacement. A target adder that drops the +1, or zero-extends the displacement, would land on the wrong PC. It offers non-qualifying results, issues during the busy window, and changes the flags in the same edge as a branch. A design that latched too freely, ended the busy window one cycle early or late, or used the new flags would miscount cycles or resolve on the wrong flags.

// File: rtl/br_pkg.sv
package br_pkg;
    localparam int unsigned XLEN = 32;
    localparam logic [5:0] BR_OPCODE = 6'b011010;
    localparam int unsigned MAX_REG = 27;

    typedef struct packed {
        logic n;
        logic z;
        logic v;
        logic c;
    } flags_t;

    typedef enum logic [4:0] {
        CC_ALWAYS = 5'd0,  CC_CS   = 5'd1,  CC_LS   = 5'd2,  CC_HI   = 5'd3,
        CC_CC     = 5'd4,  CC_EQ   = 5'd5,  CC_NE   = 5'd6,  CC_LT   = 5'd7,
        CC_LE     = 5'd8,  CC_GT   = 5'd9,  CC_GE   = 5'd10, CC_VC   = 5'd11,
        CC_VS     = 5'd12, CC_PL   = 5'd13, CC_MI   = 5'd14, CC_POS  = 5'd15,
        CC_NPOS   = 5'd16, CC_CORV = 5'd17, CC_NCV  = 5'd18, CC_ZORV = 5'd19
    } cond_t;
endpackage

// File: rtl/br_cond_eval.sv
module br_cond_eval
    import br_pkg::*;
(
    input  logic [4:0] cond,
    input  flags_t     fl,
    output logic       pass
);
    logic lt;
    always_comb begin
        lt = fl.n ^ fl.v;
        case (cond)
            CC_ALWAYS: pass = 1'b1;
            CC_CS:     pass = fl.c;
            CC_LS:     pass = fl.c | fl.z;
            CC_HI:     pass = !fl.c && !fl.z;
            CC_CC:     pass = !fl.c;
            CC_EQ:     pass = fl.z;
            CC_NE:     pass = !fl.z;
            CC_LT:     pass = lt;
            CC_LE:     pass = lt | fl.z;
            CC_GT:     pass = !lt && !fl.z;
            CC_GE:     pass = !lt;
            CC_VC:     pass = !fl.v;
            CC_VS:     pass = fl.v;
            CC_PL:     pass = !fl.n;
            CC_MI:     pass = fl.n;
            CC_POS:    pass = !fl.n && !fl.z;
            CC_NPOS:   pass = fl.n | fl.z;
            CC_CORV:   pass = fl.c | fl.v;
            CC_NCV:    pass = !fl.c && !fl.v;
            CC_ZORV:   pass = fl.z | fl.v;
            default:   pass = 1'b0;
        endcase
    end
endmodule

// File: rtl/br_target_gen.sv
module br_target_gen #(
    parameter int unsigned AW = 32,
    parameter int unsigned DW = 16
) (
    input  logic          rel_mode,
    input  logic [AW-1:0] pc,
    input  logic [DW-1:0] disp,
    input  logic [AW-1:0] reg_val,
    output logic [AW-1:0] seq_pc,
    output logic [AW-1:0] target
);
    localparam int unsigned EXT = AW - DW;
    logic [AW-1:0] disp_sx;
    always_comb begin
        disp_sx = {{EXT{disp[DW-1]}}, disp};
        seq_pc  = pc + AW'(1);
        target  = rel_mode ? (seq_pc + disp_sx) : reg_val;
    end
endmodule

// File: rtl/br_flag_qual.sv
module br_flag_qual #(
    parameter int unsigned RW = 5,
    parameter int unsigned EXT_REGS = 8
) (
    input  logic          valid,
    input  logic [RW-1:0] dst,
    input  logic          is_cmp,
    output logic          load
);
    always_comb begin
        load = valid && (is_cmp || (32'(dst) < EXT_REGS));
    end
endmodule

// File: rtl/br_resolve_unit.sv
module br_resolve_unit
    import br_pkg::*;
#(
    parameter int unsigned TAKEN_CYCLES = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        issue_valid,
    input  logic [31:0] instr,
    input  logic [31:0] instr_pc,
    output logic [4:0]  rf_idx,
    input  logic [31:0] rf_data,
    input  logic        res_valid,
    input  logic [4:0]  res_dst,
    input  logic        res_cmp,
    input  logic [3:0]  res_flags,
    output logic        busy,
    output logic        resolve_valid,
    output logic        taken,
    output logic        flush,
    output logic [31:0] new_pc,
    output logic [3:0]  flags
);
    localparam int unsigned CW = (TAKEN_CYCLES > 2) ? $clog2(TAKEN_CYCLES) : 1;
    localparam logic [CW-1:0] HOLD = CW'(TAKEN_CYCLES - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          rvld;
        logic          tkn;
        logic          fls;
        logic [31:0]   npc;
        flags_t        fl;
    } state_t;

    state_t s_q, s_d;

    logic        is_branch, accept, cond_ok, idx_ok, flag_load;
    logic [31:0] seq_pc, target;

    assign rf_idx = instr[4:0];

    br_cond_eval u_cond (
        .cond (instr[20:16]),
        .fl   (s_q.fl),
        .pass (cond_ok)
    );

    br_target_gen #(.AW(32), .DW(16)) u_tgt (
        .rel_mode (instr[25]),
        .pc       (instr_pc),
        .disp     (instr[15:0]),
        .reg_val  (rf_data),
        .seq_pc   (seq_pc),
        .target   (target)
    );

    br_flag_qual #(.RW(5), .EXT_REGS(8)) u_qual (
        .valid  (res_valid),
        .dst    (res_dst),
        .is_cmp (res_cmp),
        .load   (flag_load)
    );

    always_comb begin
        s_d       = s_q;
        is_branch = (instr[31:26] == BR_OPCODE);
        accept    = issue_valid && is_branch && (s_q.cnt == '0);
        idx_ok    = instr[25] || (32'(instr[4:0]) <= MAX_REG);

        s_d.rvld = accept;
        s_d.tkn  = accept && cond_ok && idx_ok;
        s_d.fls  = s_d.tkn;
        if (accept) begin
            s_d.npc = s_d.tkn ? target : seq_pc;
        end

        if (s_d.tkn) begin
            s_d.cnt = HOLD;
        end else if (s_q.cnt != '0) begin
            s_d.cnt = s_q.cnt - CW'(1);
        end

        if (flag_load) begin
            s_d.fl = flags_t'(res_flags);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy          = (s_q.cnt != '0);
    assign resolve_valid = s_q.rvld;
    assign taken         = s_q.tkn;
    assign flush         = s_q.fls;
    assign new_pc        = s_q.npc;
    assign flags         = s_q.fl;
endmodule

// File: rtl/br_resolve_checker.sv
module br_resolve_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        issue_valid,
    input logic [31:0] instr_pc,
    input logic        res_valid,
    input logic [4:0]  res_dst,
    input logic        res_cmp,
    input logic        busy,
    input logic        resolve_valid,
    input logic        taken,
    input logic        flush,
    input logic [31:0] new_pc,
    input logic [3:0]  flags
);
    p_flush_only_taken_r7: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> (taken && resolve_valid))
        else $error("flush without taken branch");

    p_taken_sets_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        taken |-> busy)
        else $error("taken branch not busy");

    p_no_issue_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !resolve_valid)
        else $error("branch accepted while busy");

    p_seq_pc_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && !busy) |=> ((resolve_valid && !taken) -> (new_pc == $past(instr_pc) + 32'd1)))
        else $error("fall-through PC wrong");

    p_flags_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(res_valid && (res_cmp || res_dst < 5'd8)) |=> $stable(flags))
        else $error("flags changed without qualifying result");
endmodule

bind br_resolve_unit br_resolve_checker u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .issue_valid   (issue_valid),
    .instr_pc      (instr_pc),
    .res_valid     (res_valid),
    .res_dst       (res_dst),
    .res_cmp       (res_cmp),
    .busy          (busy),
    .resolve_valid (resolve_valid),
    .taken         (taken),
    .flush         (flush),
    .new_pc        (new_pc),
    .flags         (flags)
);

// File: tb/br_resolve_unit_test.sv
module br_resolve_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        issue_valid = 1'b0;
    logic [31:0] instr = '0;
    logic [31:0] instr_pc = '0;
    logic [4:0]  rf_idx;
    logic [31:0] rf_data;
    logic        res_valid = 1'b0;
    logic [4:0]  res_dst = '0;
    logic        res_cmp = 1'b0;
    logic [3:0]  res_flags = '0;
    logic        busy, resolve_valid, taken, flush;
    logic [31:0] new_pc;
    logic [3:0]  flags;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 0;

    localparam logic [5:0] OPC = 6'b011010;

    always #2 clk = ~clk;

    assign rf_data = 32'hC000_0000 + {25'd0, rf_idx, 2'b00};

    br_resolve_unit uut (
        .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .instr(instr),
        .instr_pc(instr_pc), .rf_idx(rf_idx), .rf_data(rf_data),
        .res_valid(res_valid), .res_dst(res_dst), .res_cmp(res_cmp),
        .res_flags(res_flags), .busy(busy), .resolve_valid(resolve_valid),
        .taken(taken), .flush(flush), .new_pc(new_pc), .flags(flags)
    );

    // {flags NZVC, cond, expected taken}
    localparam logic [9:0] VEC [14] = '{
        {4'b0000, 5'd0,  1'b1}, {4'b0000, 5'd5,  1'b0},
        {4'b0100, 5'd5,  1'b1}, {4'b0100, 5'd6,  1'b0},
        {4'b1000, 5'd7,  1'b1}, {4'b1010, 5'd7,  1'b0},
        {4'b0001, 5'd1,  1'b1}, {4'b0001, 5'd4,  1'b0},
        {4'b0000, 5'd3,  1'b1}, {4'b0100, 5'd8,  1'b1},
        {4'b0000, 5'd9,  1'b1}, {4'b0010, 5'd10, 1'b0},
        {4'b1111, 5'd25, 1'b0}, {4'b0000, 5'd15, 1'b1}
    };

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic set_flags(input logic [4:0] dst, input logic cmp, input logic [3:0] f);
        @(negedge clk);
        res_valid = 1'b1; res_dst = dst; res_cmp = cmp; res_flags = f;
        @(negedge clk);
        res_valid = 1'b0;
    endtask

    task automatic branch(input logic [4:0] cond, input logic mode, input logic [15:0] low, input logic [31:0] pc);
        @(negedge clk);
        issue_valid = 1'b1;
        instr = {OPC, mode, 4'b0000, cond, low};
        instr_pc = pc;
        @(negedge clk);
        issue_valid = 1'b0;
    endtask

    task automatic drain();
        while (busy) @(negedge clk);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual %0d expected %0d", cycles, 100000);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(!busy && !resolve_valid && !taken && !flush, "R1", {28'd0, busy, resolve_valid, taken, flush}, 32'd0);
        chk(flags == 4'd0, "R1 flags", {28'd0, flags}, 32'd0);
        rst_n = 1'b1;

        // R3 condition table walk, PC-relative, taken target pc+1+16
        foreach (VEC[i]) begin
            set_flags(5'd0, 1'b0, VEC[i][9:6]);
            branch(VEC[i][5:1], 1'b1, 16'h0010, 32'h0000_1000 + 32'(i));
            chk(resolve_valid && taken == VEC[i][0], "R3", {31'd0, taken}, {31'd0, VEC[i][0]});
            chk(new_pc == (VEC[i][0] ? 32'h0000_1011 + 32'(i) : 32'h0000_1001 + 32'(i)),
                "R3 pc", new_pc, VEC[i][0] ? 32'h0000_1011 + 32'(i) : 32'h0000_1001 + 32'(i));
            drain();
        end

        // R7 / R8: flush and busy length
        set_flags(5'd3, 1'b0, 4'b0000);
        branch(5'd0, 1'b1, 16'h0000, 32'h200);
        chk(flush && taken, "R7 flush", {31'd0, flush}, 32'd1);
        begin
            int n = 0;
            while (busy) begin n++; @(negedge clk); end
            chk(n == 3, "R8 busy length", n, 32'd3);
        end
        chk(!flush && !resolve_valid, "R2 single pulse", {31'd0, resolve_valid}, 32'd0);

        // R8: issue during busy ignored
        branch(5'd0, 1'b1, 16'h0000, 32'h300);
        branch(5'd0, 1'b1, 16'h0040, 32'h400);
        chk(!resolve_valid && new_pc == 32'h301, "R8 blocked", new_pc, 32'h301);
        drain();

        // R2 wrong opcode ignored
        @(negedge clk);
        issue_valid = 1'b1; instr = {6'b011011, 1'b1, 4'd0, 5'd0, 16'h0005}; instr_pc = 32'h500;
        @(negedge clk);
        issue_valid = 1'b0;
        chk(!resolve_valid && !taken && !busy && new_pc == 32'h301, "R2 opcode", new_pc, 32'h301);

        // R4 fall-through wraps
        set_flags(5'd0, 1'b0, 4'b0000);
        branch(5'd5, 1'b1, 16'h0005, 32'hFFFF_FFFF);
        chk(resolve_valid && !taken && !flush && !busy && new_pc == 32'h0, "R4 wrap", new_pc, 32'h0);

        // R6 wrap and negative displacement
        branch(5'd0, 1'b1, 16'h0005, 32'hFFFF_FFFF);
        chk(taken && new_pc == 32'h5, "R6 wrap", new_pc, 32'h5);
        drain();
        branch(5'd0, 1'b1, 16'h8000, 32'h100);
        chk(taken && new_pc == 32'hFFFF_8101, "R6 neg", new_pc, 32'hFFFF_8101);
        drain();

        // R5 register mode
        branch(5'd0, 1'b0, 16'h001B, 32'h700);
        chk(taken && new_pc == 32'hC000_006C, "R5 reg27", new_pc, 32'hC000_006C);
        drain();
        branch(5'd0, 1'b0, 16'h001C, 32'h800);
        chk(resolve_valid && !taken && new_pc == 32'h801, "R5 idx28", new_pc, 32'h801);

        // R9 flag qualification
        set_flags(5'd8, 1'b0, 4'b1111);
        chk(flags == 4'b0000, "R9 ignore dst8", {28'd0, flags}, 32'd0);
        set_flags(5'd12, 1'b1, 4'b0100);
        chk(flags == 4'b0100, "R9 cmp", {28'd0, flags}, 32'h4);
        set_flags(5'd7, 1'b0, 4'b1001);
        chk(flags == 4'b1001, "R9 dst7", {28'd0, flags}, 32'h9);
        branch(5'd0, 1'b1, 16'h0001, 32'h900);
        chk(flags == 4'b1001, "R9 branch keeps flags", {28'd0, flags}, 32'h9);
        drain();

        // R3 same-edge flag write uses old flags (Z=0 -> EQ not taken)
        @(negedge clk);
        issue_valid = 1'b1; instr = {OPC, 1'b1, 4'd0, 5'd5, 16'h0010}; instr_pc = 32'hA00;
        res_valid = 1'b1; res_dst = 5'd1; res_cmp = 1'b0; res_flags = 4'b0100;
        @(negedge clk);
        issue_valid = 1'b0; res_valid = 1'b0;
        chk(resolve_valid && !taken && flags == 4'b0100, "R3 old flags", {31'd0, taken}, 32'd0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule